// File: doc/BRIEF.md
# Timestamp Counter Control Unit

This block keeps a running time value and lets software steer it through a single 32-bit control register. One write can start or stop the counter, zero it, or snapshot the current time into a second register that software reads back later. Command bits act once and clear themselves, so software writes a whole word without first reading the register.

The unit has two timekeeping sources. In master mode the internal counter advances by one on every clock while it is enabled and wraps to zero past its maximum. In slave mode the internal counter freezes and the current-time output follows an externally supplied time input. In that mode a write changes only the mode bit and the snapshot command. A snapshot always takes whichever time the output shows in the cycle of the write. Reads are combinational. Word address 0 selects the control register, word address 1 selects the captured time, and every other address reads zero.

Top module: `time_counter_ctrl`

## Requirements
- R1: After reset the control register reads 0, the captured time reads 0, the unit is in master mode and stopped, and the time output is 0.
- R2: Control bit 0 is the enable. In master mode the time output rises by exactly 1 per clock while enable is 1 and holds while it is 0.
- R3: At its all-ones value the enabled master counter goes to zero on the next clock and then keeps counting.
- R4: Writing 1 to control bit 9 (restart) in master mode makes the time output 0 after the write's clock edge and leaves the enable unchanged. An enabled counter then counts up from 0.
- R5: In master mode a write with bit 9 set ignores every other bit of that word: enable, mode and captured time keep their previous values.
- R6: Writing 1 to control bit 11 (capture) latches the time output of the write cycle into the captured-time register, read at word address 1.
- R7: Control bit 13 selects slave mode. While it is 1 the time output equals the external time input, and the internal count holds. On return to master mode the count resumes from the value it held.
- R8: In slave mode a control write updates only the mode bit and the capture command. Enable and restart have no effect, and capture latches the external time.
- R9: A control read returns enable in bit 0 and slave mode in bit 13. All other bits read 0, including the command bits restart and capture after they have acted.
- R10: Reads at any word address other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the combinational read |
| rd_data | output | DATA_W | Read data |
| ext_time | input | TIME_W | Externally supplied time, used in slave mode |
| time_out | output | TIME_W | Current time |

## Verification
The assertions check on every cycle the properties that hold from one cycle to the next:
- the unit-step advance and the wrap at all-ones;
- the zeroing and priority of restart;
- the captured value matching the previous cycle's time;
- the time output following the external input in slave mode;
- the frozen enable under slave-mode writes;
- zeros in the reserved control bits.

Only the bench scenarios can show behaviour that spans several writes. The internal count is held through a slave-mode excursion and is visible again on return to master mode. A restart or enable written during slave mode has no effect later. The full wrap sequence is exercised end to end.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Control register bit positions (software-visible encoding)
    localparam int BIT_EN      = 0;
    localparam int BIT_RESTART = 9;
    localparam int BIT_CAPTURE = 11;
    localparam int BIT_SLAVE   = 13;

    // Word addresses
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CAPT = 1;

    // Decoded action for one write cycle
    typedef struct packed {
        logic restart;
        logic capture;
        logic load_en;
        logic load_slave;
        logic en;
        logic slave;
    } tsc_cmd_t;

endpackage

// File: rtl/tsc_cmd_decode.sv
module tsc_cmd_decode
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slave_q,
    output tsc_cmd_t          cmd
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cmd = '0;
        if (wr_ctrl) begin
            if (slave_q) begin
                // slave mode: only mode bit and capture are honoured
                cmd.capture    = wr_data[BIT_CAPTURE];
                cmd.load_slave = 1'b1;
                cmd.slave      = wr_data[BIT_SLAVE];
            end else if (wr_data[BIT_RESTART]) begin
                // restart outranks every other bit of the word
                cmd.restart = 1'b1;
            end else begin
                cmd.capture    = wr_data[BIT_CAPTURE];
                cmd.load_en    = 1'b1;
                cmd.en         = wr_data[BIT_EN];
                cmd.load_slave = 1'b1;
                cmd.slave      = wr_data[BIT_SLAVE];
            end
        end
    end

endmodule

// File: rtl/tsc_core.sv
module tsc_core
    import tsc_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tsc_cmd_t          cmd,
    input  logic [TIME_W-1:0] ext_time,
    output logic [TIME_W-1:0] time_out,
    output logic              en_o,
    output logic              slave_o,
    output logic [TIME_W-1:0] cap_o
);

    typedef struct packed {
        logic              en;
        logic              slave;
        logic [TIME_W-1:0] cnt;
        logic [TIME_W-1:0] cap;
    } core_state_t;

    core_state_t state_d, state_q;
    logic [TIME_W-1:0] now_time;

    assign now_time = state_q.slave ? ext_time : state_q.cnt;

    always_comb begin
        state_d = state_q;
        if (state_q.en && !state_q.slave) begin
            state_d.cnt = state_q.cnt + TIME_W'(1);
        end
        if (cmd.restart) begin
            state_d.cnt = '0;
        end
        if (cmd.load_en) begin
            state_d.en = cmd.en;
        end
        if (cmd.load_slave) begin
            state_d.slave = cmd.slave;
        end
        if (cmd.capture) begin
            state_d.cap = now_time;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign time_out = now_time;
    assign en_o     = state_q.en;
    assign slave_o  = state_q.slave;
    assign cap_o    = state_q.cap;

endmodule

// File: rtl/tsc_readback.sv
module tsc_readback
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TIME_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              en,
    input  logic              slave,
    input  logic [TIME_W-1:0] cap,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[BIT_EN]    = en;
            rd_data[BIT_SLAVE] = slave;
        end else if (rd_addr == ADDR_W'(ADDR_CAPT)) begin
            rd_data[TIME_W-1:0] = cap;
        end
    end

endmodule

// File: rtl/time_counter_ctrl.sv
module time_counter_ctrl
    import tsc_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TIME_W-1:0] ext_time,
    output logic [TIME_W-1:0] time_out
);

    tsc_cmd_t          cmd;
    logic              wr_ctrl;
    logic              ctl_en;
    logic              ctl_slave;
    logic [TIME_W-1:0] ctl_cap;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

    tsc_cmd_decode #(.DATA_W(DATA_W)) u_decode (
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .slave_q (ctl_slave),
        .cmd     (cmd)
    );

    tsc_core #(.TIME_W(TIME_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ext_time (ext_time),
        .time_out (time_out),
        .en_o     (ctl_en),
        .slave_o  (ctl_slave),
        .cap_o    (ctl_cap)
    );

    tsc_readback #(.DATA_W(DATA_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_readback (
        .rd_addr (rd_addr),
        .en      (ctl_en),
        .slave   (ctl_slave),
        .cap     (ctl_cap),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
    import tsc_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [TIME_W-1:0] ext_time,
    input logic [TIME_W-1:0] time_out,
    input logic              en,
    input logic              slave,
    input logic [TIME_W-1:0] cap
);

    localparam logic [TIME_W-1:0] T_MAX = '1;

    logic [DATA_W-1:0] ctrl_mask;
    logic              wr_ctrl;
    always_comb begin
        ctrl_mask = '0;
        ctrl_mask[BIT_EN]    = 1'b1;
        ctrl_mask[BIT_SLAVE] = 1'b1;
    end
    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (time_out == '0 && !en && !slave && cap == '0));

    // R2
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !slave && !wr_ctrl && time_out != T_MAX) |=>
            time_out == $past(time_out) + TIME_W'(1));

    // R2
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !slave && !wr_ctrl) |=> $stable(time_out));

    // R3
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !slave && !wr_ctrl && time_out == T_MAX) |=> time_out == '0);

    // R4
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !slave && wr_data[BIT_RESTART]) |=> (time_out == '0 && $stable(en)));

    // R5
    a_r5_restart_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !slave && wr_data[BIT_RESTART]) |=> ($stable(slave) && $stable(cap)));

    // R6
    a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[BIT_CAPTURE] && (slave || !wr_data[BIT_RESTART])) |=>
            cap == $past(time_out));

    // R7
    a_r7_slave_follow: assert property (@(posedge clk) disable iff (!rst_n)
        slave |-> time_out == ext_time);

    // R8
    a_r8_slave_en_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && wr_ctrl) |=> $stable(en));

    // R9
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADDR_CTRL)) |-> (rd_data & ~ctrl_mask) == '0);

    // R10
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != ADDR_W'(ADDR_CTRL) && rd_addr != ADDR_W'(ADDR_CAPT)) |-> rd_data == '0);

endmodule

bind time_counter_ctrl tsc_checker #(
    .TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_tsc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ext_time (ext_time),
    .time_out (time_out),
    .en       (ctl_en),
    .slave    (ctl_slave),
    .cap      (ctl_cap)
);

// File: tb/time_counter_ctrl_bench.sv
`timescale 1ns/1ps
module time_counter_ctrl_bench;

    localparam int TIME_W = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int T_MAX  = (1 << TIME_W) - 1;

    localparam logic [31:0] C_EN  = 32'h0000_0001;
    localparam logic [31:0] C_RST = 32'h0000_0200;
    localparam logic [31:0] C_CAP = 32'h0000_0800;
    localparam logic [31:0] C_SLV = 32'h0000_2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [TIME_W-1:0] ext_time = '0;
    logic [TIME_W-1:0] time_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    time_counter_ctrl #(.TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_time_counter_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_time(ext_time), .time_out(time_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic reg_write(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] val);
        rd_addr = ADDR_W'(addr);
        #1;
        val = rd_data;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(0, v);
        check(v == 0, "R1 ctrl after reset", v, 0);
        reg_read(1, v);
        check(v == 0, "R1 capture after reset", v, 0);
        wait_cycles(5);
        check(time_out == 0, "R1 time stays zero", time_out, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        int t0;
        reg_write(0, C_EN);
        t0 = time_out;
        wait_cycles(7);
        check(time_out == t0 + 7, "R2 counts by one", time_out, t0 + 7);
        reg_read(0, v);
        check(v == 1, "R9 ctrl shows enable", v, 1);
        reg_write(0, 0);
        t0 = time_out;
        wait_cycles(6);
        check(time_out == t0, "R2 holds when stopped", time_out, t0);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        reg_write(0, C_EN);
        wait_cycles(10);
        reg_write(0, C_RST);
        check(time_out == 0, "R4 restart zeroes", time_out, 0);
        wait_cycles(3);
        check(time_out == 3, "R4 counts from zero", time_out, 3);
        reg_read(0, v);
        check(v == 1, "R4 enable kept and R9 restart self-clears", v, 1);
    endtask

    task automatic t_restart_priority;
        logic [31:0] v, cap0;
        wait_cycles(4);
        reg_read(1, cap0);
        reg_write(0, C_RST | C_SLV | C_CAP);
        check(time_out == 0, "R5 restart still zeroes", time_out, 0);
        reg_read(0, v);
        check(v == 1, "R5 enable and mode unchanged", v, 1);
        reg_read(1, v);
        check(v == cap0, "R5 capture ignored", v, cap0);
    endtask

    task automatic t_capture;
        logic [31:0] v;
        int snap;
        wait_cycles(20);
        snap = time_out;
        reg_write(0, C_EN | C_CAP);
        reg_read(1, v);
        check(v == snap, "R6 captured time", v, snap);
        reg_read(0, v);
        check(v == 1, "R6 R9 capture bit reads zero", v, 1);
        check(time_out == snap + 1, "R6 counter keeps running", time_out, snap + 1);
    endtask

    task automatic t_slave;
        logic [31:0] v;
        int c;
        ext_time = 12'h123;
        c = time_out;
        reg_write(0, C_SLV | C_EN);
        check(time_out == 12'h123, "R7 follows external time", time_out, 12'h123);
        ext_time = 12'h456;
        #1;
        check(time_out == 12'h456, "R7 tracks external change", time_out, 12'h456);
        reg_write(0, C_SLV);
        reg_read(0, v);
        check(v == (C_SLV | C_EN), "R8 enable ignored in slave", v, C_SLV | C_EN);
        reg_write(0, C_SLV | C_RST);
        reg_read(0, v);
        check(v == (C_SLV | C_EN), "R8 restart ignored, still slave", v, C_SLV | C_EN);
        ext_time = 12'h789;
        reg_write(0, C_SLV | C_CAP);
        reg_read(1, v);
        check(v == 12'h789, "R8 capture latches external time", v, 12'h789);
        wait_cycles(9);
        reg_write(0, C_EN);
        check(time_out == c + 1, "R7 count held through slave", time_out, c + 1);
        reg_read(0, v);
        check(v == 1, "R7 back in master", v, 1);
    endtask

    task automatic t_wrap;
        reg_write(0, C_RST);
        wait_cycles(T_MAX);
        check(time_out == T_MAX, "R3 reaches maximum", time_out, T_MAX);
        wait_cycles(1);
        check(time_out == 0, "R3 wraps to zero", time_out, 0);
        wait_cycles(1);
        check(time_out == 1, "R3 counts after wrap", time_out, 1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        reg_read(2, v);
        check(v == 0, "R10 address 2 reads zero", v, 0);
        reg_read(3, v);
        check(v == 0, "R10 address 3 reads zero", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_restart();
        t_restart_priority();
        t_capture();
        t_slave();
        t_wrap();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule